// File: doc/BRIEF.md
# Frame Interrupt Coalescing Unit

This block sits beside the descriptor write-back path of a DMA-driven network controller. It turns per-descriptor completions into fewer interrupts. Each completion arrives with two attributes: whether the descriptor closes a frame, and whether that descriptor requested an interrupt. The completion becomes an event only once memory has acknowledged the write-back. A completion on a descriptor that does not close a frame raises the buffer event. A completion on a frame's closing descriptor that requested an interrupt is a counted frame.

With coalescing enabled, counted frames are gathered. The frame event is raised when the count reaches a programmed threshold, or when a programmed number of cycles has passed since the first gathered frame, whichever comes first. With coalescing disabled, every counted frame raises the frame event at once. The thresholds that are in use are captured only while coalescing is disabled, so software loads new values by clearing and then setting the enable. One instance serves transmit and a second, identical instance serves receive.

Top module: `frame_irq_coalesce`

## Requirements
- R1: An acknowledged completion whose closing flag is 0 sets the buffer event, bit 0 of the event register, whatever its request flag.
- R2: A completion has no effect until `wb_ack_i` is seen. The ack may come in the same cycle as `cmpl_valid_i` or in a later one, and the completion's attributes are held until then. An ack with nothing outstanding does nothing.
- R3: An acknowledged completion with closing flag 1 and request flag 0 neither sets the frame event (bit 1) nor advances the frame count.
- R4: While enabled, the frame event is set on the clock edge that registers the counted frame which brings the count to the active count threshold. A count threshold of 0 or 1 sets it on every counted frame.
- R5: While enabled and with a nonzero active time threshold T, the frame event is set T cycles after the edge that registered the first counted frame since the last firing. The timer does not run while no frame is gathered. T = 0 disables the timer path.
- R6: A firing returns both the frame count and the timer to zero, so the next firing needs a full threshold again.
- R7: While disabled, each acknowledged counted frame sets the frame event on the acknowledging edge.
- R8: Threshold writes made while enabled do not change the active thresholds or the running count. Clearing the enable discards the gathered frames, and setting it again starts with the thresholds last written.
- R9: Writing 1 to an event bit clears it and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R10: `irq_o` is high exactly when some event bit is set and its mask bit is set. Mask bit 0 covers the buffer event and mask bit 1 covers the frame event.
- R11: Register map, with reads zero-extended: address 0 is the enable in bit 0, address 1 the mask, address 2 the count threshold, address 3 the time threshold, address 4 the events (write-one-to-clear).
- R12: After reset every register reads 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmpl_valid_i | input | 1 | Descriptor completion presented (one-cycle pulse) |
| cmpl_last_i | input | 1 | Completed descriptor closes a frame |
| cmpl_ireq_i | input | 1 | Completed descriptor requested an interrupt |
| wb_ack_i | input | 1 | Memory acknowledged the descriptor write-back |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that at most one write-back is outstanding. A new `cmpl_valid_i` therefore arrives only after the previous completion has been acknowledged, or in the same cycle as that acknowledge. The stimulus keeps to this: each completion is followed by its ack after a random delay of zero to two cycles, before the next completion starts. Threshold values are written only while the enable is low, except in the cases that check that a write made while enabled is deferred. The randomized frame sequences run with the timer path off, so the expected frame event follows from the count alone. The timer path is covered by directed cases.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTHR = 3'd2;
  localparam logic [ADDR_W-1:0] A_TTHR = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;
  localparam int unsigned NUM_EV = 2;
  localparam int unsigned EV_BUF = 0;
  localparam int unsigned EV_FRM = 1;

  typedef struct packed {
    logic last;
    logic ireq;
  } cmpl_t;
endpackage

// File: rtl/fic_wb_track.sv
module fic_wb_track
  import fic_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmpl_valid_i,
  input  logic cmpl_last_i,
  input  logic cmpl_ireq_i,
  input  logic wb_ack_i,
  output logic buf_evt_o,
  output logic frm_evt_o
);
  cmpl_t pend_q, cur;
  logic  pend_vld_q, take;

  always_comb begin
    cur = cmpl_valid_i ? cmpl_t'({cmpl_last_i, cmpl_ireq_i}) : pend_q;
    take      = wb_ack_i & (cmpl_valid_i | pend_vld_q);
    buf_evt_o = take & ~cur.last;
    frm_evt_o = take & cur.last & cur.ireq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
    end else if (cmpl_valid_i && !wb_ack_i) begin
      pend_vld_q <= 1'b1;
      pend_q     <= {cmpl_last_i, cmpl_ireq_i};
    end else if (wb_ack_i) begin
      pend_vld_q <= 1'b0;
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_q && !wb_ack_i |=> pend_vld_q && $stable(pend_q)); // R2
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_i && !cmpl_valid_i |=> !pend_vld_q); // R2
endmodule

// File: rtl/fic_coalesce.sv
module fic_coalesce #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cthr_i,
  input  logic [TIM_W-1:0] tthr_i,
  input  logic             frm_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q, act_c_q;
  logic [TIM_W-1:0] tmr_q, act_t_q;
  logic [CNT_W:0]   cnt_inc;
  logic [TIM_W:0]   tmr_inc;
  logic             pending, cnt_hit, tmr_hit;

  always_comb begin
    pending = (cnt_q != '0);
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    tmr_inc = {1'b0, tmr_q} + 1'b1;
    cnt_hit = frm_i && (act_c_q <= CNT_W'(1) || cnt_inc >= {1'b0, act_c_q});
    tmr_hit = pending && (act_t_q != '0) && (tmr_inc == {1'b0, act_t_q});
    fire_o  = en_i ? (cnt_hit | tmr_hit) : frm_i;
  end

  // Active thresholds track the written values only while disabled.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      tmr_q   <= '0;
      act_c_q <= '0;
      act_t_q <= '0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      tmr_q   <= '0;
      act_c_q <= cthr_i;
      act_t_q <= tthr_i;
    end else if (fire_o) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else begin
      if (frm_i) cnt_q <= cnt_inc[CNT_W-1:0];
      if (pending && act_t_q != '0) tmr_q <= tmr_inc[TIM_W-1:0];
    end
  end

  AST_TIMER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == '0 |-> tmr_q == '0); // R5
  AST_CNT_BELOW_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && act_c_q > CNT_W'(1) |-> cnt_q < act_c_q); // R4
  AST_FIRE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> cnt_q == '0); // R6
  AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0 && tmr_q == '0); // R8
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) |-> $stable(act_c_q) && $stable(act_t_q)); // R8
endmodule

// File: rtl/fic_regs.sv
module fic_regs
  import fic_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TIM_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              buf_set_i,
  input  logic              frm_set_i,
  output logic              en_o,
  output logic [CNT_W-1:0]  cthr_o,
  output logic [TIM_W-1:0]  tthr_o,
  output logic              irq_o
);
  logic              en_q;
  logic [NUM_EV-1:0] mask_q, evt_q, ev_set, ev_clr;
  logic [CNT_W-1:0]  cthr_q;
  logic [TIM_W-1:0]  tthr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      cthr_q <= '0;
      tthr_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL:  en_q   <= reg_wdata_i[0];
        A_MASK:  mask_q <= reg_wdata_i[NUM_EV-1:0];
        A_CTHR:  cthr_q <= reg_wdata_i[CNT_W-1:0];
        A_TTHR:  tthr_q <= reg_wdata_i[TIM_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ev_set         = '0;
    ev_set[EV_BUF] = buf_set_i;
    ev_set[EV_FRM] = frm_set_i;
    ev_clr = (reg_we_i && reg_addr_i == A_EVT) ? reg_wdata_i[NUM_EV-1:0] : '0;
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        evt_q[i] <= 1'b0;
      else if (ev_set[i]) evt_q[i] <= 1'b1;
      else if (ev_clr[i]) evt_q[i] <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = DW'(en_q);
      A_MASK:  reg_rdata_o = DW'(mask_q);
      A_CTHR:  reg_rdata_o = DW'(cthr_q);
      A_TTHR:  reg_rdata_o = DW'(tthr_q);
      A_EVT:   reg_rdata_o = DW'(evt_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign cthr_o = cthr_q;
  assign tthr_o = tthr_q;
  assign irq_o  = |(evt_q & mask_q);

  AST_FRM_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[EV_FRM]) |-> $past(frm_set_i)); // R7
  AST_BUF_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[EV_BUF]) |-> $past(buf_set_i)); // R1
  AST_W1C_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == A_EVT && reg_wdata_i[NUM_EV-1:0] == '0
    |=> (evt_q & $past(evt_q)) == $past(evt_q)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == '0 |-> !irq_o); // R10
endmodule

// File: rtl/frame_irq_coalesce.sv
module frame_irq_coalesce
  import fic_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TIM_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmpl_valid_i,
  input  logic              cmpl_last_i,
  input  logic              cmpl_ireq_i,
  input  logic              wb_ack_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  logic             buf_evt, frm_evt, fire, en;
  logic [CNT_W-1:0] cthr;
  logic [TIM_W-1:0] tthr;

  fic_wb_track u_track (
    .clk_i, .rst_ni, .cmpl_valid_i, .cmpl_last_i, .cmpl_ireq_i, .wb_ack_i,
    .buf_evt_o(buf_evt), .frm_evt_o(frm_evt)
  );

  fic_coalesce #(.CNT_W(CNT_W), .TIM_W(TIM_W)) u_coal (
    .clk_i, .rst_ni, .en_i(en), .cthr_i(cthr), .tthr_i(tthr),
    .frm_i(frm_evt), .fire_o(fire)
  );

  fic_regs #(.DW(DW), .CNT_W(CNT_W), .TIM_W(TIM_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .buf_set_i(buf_evt), .frm_set_i(fire), .en_o(en), .cthr_o(cthr),
    .tthr_o(tthr), .irq_o
  );

  AST_NO_FIRE_WITHOUT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_ack_i && !en |-> !fire); // R2
endmodule

// File: tb/tb_frame_irq_coalesce.sv
module tb_frame_irq_coalesce;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 0, rst_ni = 0;
  logic cmpl_valid = 0, cmpl_last = 0, cmpl_ireq = 0, wb_ack = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int n_tests = 0, n_fail = 0;

  frame_irq_coalesce dut (
    .clk_i(clk), .rst_ni, .cmpl_valid_i(cmpl_valid), .cmpl_last_i(cmpl_last),
    .cmpl_ireq_i(cmpl_ireq), .wb_ack_i(wb_ack), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic cmpl(logic last, logic ireq, int ack_dly);
    @(negedge clk); cmpl_valid = 1; cmpl_last = last; cmpl_ireq = ireq;
    wb_ack = (ack_dly == 0);
    @(negedge clk); cmpl_valid = 0; wb_ack = 0;
    if (ack_dly > 0) begin
      repeat (ack_dly - 1) @(negedge clk);
      wb_ack = 1; @(negedge clk); wb_ack = 0;
    end
  endtask

  function automatic logic [1:0] rnd_exp_evt(logic buf_e, logic frm_e);
    return {frm_e, buf_e};
  endfunction

  task automatic evt_is(string req, logic [1:0] exp);
    logic [31:0] d;
    rd(3'd4, d); check(req, d, {30'd0, exp});
  endtask

  task automatic enable(int cthr, int tthr);
    wr(3'd0, 0); wr(3'd2, cthr); wr(3'd3, tthr); wr(3'd0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R12 reset state
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); check("R12 reg", d, 0); end
    check("R12 irq", {31'd0, irq}, 0);
    // R11 readback
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); check("R11 mask", d, 3);
    wr(3'd2, 32'h1_23); rd(3'd2, d); check("R11 cthr", d, 32'h23);
    wr(3'd3, 32'h7_4567); rd(3'd3, d); check("R11 tthr", d, 32'h4567);
    wr(3'd1, 0);
    // R7 disabled: immediate frame event; R3 no request -> nothing
    wr(3'd0, 0);
    cmpl(1, 0, 0); evt_is("R3 disabled noreq", 2'b00);
    cmpl(1, 1, 0); evt_is("R7 disabled immediate", 2'b10);
    wr(3'd4, 3);
    // R1 buffer event regardless of request
    cmpl(0, 0, 1); evt_is("R1 buffer event", 2'b01);
    wr(3'd4, 3);
    // R2 completion held until ack
    @(negedge clk); cmpl_valid = 1; cmpl_last = 1; cmpl_ireq = 1;
    @(negedge clk); cmpl_valid = 0; cmpl_last = 0; cmpl_ireq = 0;
    repeat (3) @(negedge clk);
    evt_is("R2 before ack", 2'b00);
    wb_ack = 1; @(negedge clk); wb_ack = 0;
    evt_is("R2 after ack", 2'b10);
    wb_ack = 1; @(negedge clk); wb_ack = 0;
    wr(3'd4, 3); evt_is("R2 stray ack", 2'b00);
    // R4 count threshold 3, R3 enabled uncounted
    enable(3, 0);
    cmpl(1, 1, 0); cmpl(1, 0, 0); cmpl(1, 1, 2);
    evt_is("R4 R3 below thr", 2'b00);
    cmpl(1, 1, 0); evt_is("R4 reach thr", 2'b10);
    wr(3'd4, 2);
    // R6 counter cleared after fire
    cmpl(1, 1, 0); cmpl(1, 1, 0); evt_is("R6 restart count", 2'b00);
    cmpl(1, 1, 0); evt_is("R6 refire", 2'b10);
    wr(3'd4, 2);
    // R4 thr 0 and 1
    enable(0, 0); cmpl(1, 1, 0); evt_is("R4 thr0", 2'b10); wr(3'd4, 2);
    enable(1, 0); cmpl(1, 1, 0); evt_is("R4 thr1", 2'b10); wr(3'd4, 2);
    // R8 threshold write while enabled deferred; toggle clears
    enable(3, 0);
    cmpl(1, 1, 0); wr(3'd2, 1);
    cmpl(1, 1, 0); evt_is("R8 deferred thr", 2'b00);
    wr(3'd0, 0); wr(3'd0, 1);
    cmpl(1, 1, 0); evt_is("R8 new thr active", 2'b10);
    wr(3'd4, 2);
    // R5 timer fire after T cycles
    enable(10, 5);
    repeat (8) @(negedge clk);
    evt_is("R5 timer idle", 2'b00);
    cmpl(1, 1, 0);
    repeat (4) @(negedge clk);
    evt_is("R5 before T", 2'b00);
    @(negedge clk);
    evt_is("R5 at T", 2'b10);
    wr(3'd4, 2);
    repeat (12) @(negedge clk);
    evt_is("R6 timer reset after fire", 2'b00);
    // R5 T=0 disables timer
    enable(4, 0);
    cmpl(1, 1, 0); repeat (40) @(negedge clk);
    evt_is("R5 timer off", 2'b00);
    // R9 W1C
    wr(3'd0, 0); cmpl(1, 1, 0); cmpl(0, 1, 0);
    evt_is("R9 both set", 2'b11);
    wr(3'd4, 0); evt_is("R9 write zero keeps", 2'b11);
    // R10 irq masking
    wr(3'd1, 0); check("R10 mask0", {31'd0, irq}, 0);
    wr(3'd1, 2); check("R10 frm mask", {31'd0, irq}, 1);
    wr(3'd4, 1); evt_is("R9 clear buf only", 2'b10);
    wr(3'd1, 1); check("R10 buf mask no buf", {31'd0, irq}, 0);
    // R9 set wins over clear
    @(negedge clk); reg_we = 1; reg_addr = 3'd4; reg_wdata = 2;
    cmpl_valid = 1; cmpl_last = 1; cmpl_ireq = 1; wb_ack = 1;
    @(negedge clk); reg_we = 0; cmpl_valid = 0; wb_ack = 0;
    evt_is("R9 set wins", 2'b10);
    wr(3'd4, 3);
    // Random count-only phase
    begin
      int thr, mcnt;
      logic eb, ef;
      thr = $urandom_range(0, 5);
      enable(thr, 0); mcnt = 0;
      for (int i = 0; i < 300; i++) begin
        logic l, q;
        int dly;
        l = ($urandom_range(0, 3) != 0); q = $urandom_range(0, 1);
        dly = $urandom_range(0, 2);
        cmpl(l, q, dly);
        eb = !l; ef = 0;
        if (l && q) begin
          mcnt++;
          if (mcnt >= ((thr < 1) ? 1 : thr)) begin ef = 1; mcnt = 0; end
        end
        evt_is("R4 R1 random", rnd_exp_evt(eb, ef));
        wr(3'd4, 3);
        if (i % 60 == 59) begin
          thr = $urandom_range(0, 5); enable(thr, 0); mcnt = 0;
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule